// File: doc/BRIEF.md
# Cycle-Skipping Gate Controller

This block decides, once per oscillator period, whether the power switch is driven during that period. Regulation comes only from taking or skipping whole periods. There is no error amplifier and no loop compensation. On the rising edge of the period-start strobe the block samples a digitised feedback-enable level. If that level is high, and the duty window and the protection enable are both high, the gate request goes high on the next clock. If it is low, the whole period is skipped.

Once the pulse is on, three things can end it: the duty window closing, the protection enable dropping, or the current-limit comparator level after a leading-edge blanking interval has run out. After any of these, the pulse stays off until the next period start. Two wrapping counters tally the periods taken and the periods skipped, so that a bench can observe them.

The controller runs on a fast system clock. Every input arrives already synchronised to that clock. The blanking interval is a parameter counted in system clocks.

Top module: `csk_switch_ctrl`

## Requirements
- R1: After reset, `gate_req_o` is low and both tally outputs are zero.
- R2: On a rising edge of `cyc_start_i`, if `fb_en_i`, `dmax_win_i` and `prot_en_i` are all high at that clock, then `gate_req_o` is high from the next clock onwards.
- R3: If `fb_en_i` is low at the rising edge of `cyc_start_i`, then `gate_req_o` stays low for the whole period.
- R4: A change of `fb_en_i` after the sampling edge has no effect for the rest of that period. A drop does not end the pulse, and a rise does not start a pulse.
- R5: Once blanking has expired, a high `ilim_i` while the gate is on clears the gate at the next clock. The gate then stays low until the next period start, even if `ilim_i` returns low.
- R6: `ilim_i` is ignored for `BLANK_CYC` clocks after turn-on. With `ilim_i` held high from the start, the pulse therefore lasts `BLANK_CYC`+1 clocks.
- R7: A low `dmax_win_i` clears the gate at the next clock, and it blocks a turn-on at a period start.
- R8: A low `prot_en_i` forces `gate_req_o` low in the same cycle, ahead of every other input. It also clears the latched pulse, so the pulse does not come back when `prot_en_i` returns high within the period.
- R9: Each rising edge of `cyc_start_i` increments exactly one tally. `cyc_on_cnt_o` counts the periods that turned on. `cyc_skip_cnt_o` counts every other period. Both counters wrap at 2^`CNT_W`.
- R10: A `cyc_start_i` held high over several clocks counts as a single period start. The level is not re-sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | Period-start strobe from the oscillator; its rising edge samples the feedback |
| dmax_win_i | input | 1 | High while the maximum-duty window is open |
| fb_en_i | input | 1 | Digitised feedback level; high means take the period |
| ilim_i | input | 1 | Current-limit comparator level; high means over the limit |
| prot_en_i | input | 1 | Global enable from the protection logic; low forces the gate off |
| gate_req_o | output | 1 | Gate drive request |
| cyc_on_cnt_o | output | CNT_W | Wrapping count of periods that turned on |
| cyc_skip_cnt_o | output | CNT_W | Wrapping count of skipped periods |

## Verification
The assertions check rules that hold on every clock. A turn-on needs a sampled period start with all three conditions true. A skipped sample, a closed window, a dropped protection enable or a current-limit trip after blanking each leave the latch clear on the next clock. Blanking is active on the first on-cycle. Every start edge moves the combined tally by exactly one, and the tallies hold still otherwise.

Only the bench scenarios can show the pulse widths over a whole period. These cover the exact `BLANK_CYC`+1 width under a persistent over-current, and a trip that stays off after `ilim_i` falls again. They also cover feedback that toggles after sampling, a start strobe held for several clocks, and a protection drop followed by recovery inside the same period.

// File: rtl/csk_pkg.sv
package csk_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_TAKE = 2'd1,
    DEC_SKIP = 2'd2
  } csk_dec_e;

  // Period decision at a start edge: take only if every condition permits.
  function automatic csk_dec_e csk_decide(input logic start, input logic fb,
                                          input logic dmax, input logic prot);
    if (!start)                  return DEC_IDLE;
    else if (fb && dmax && prot) return DEC_TAKE;
    else                         return DEC_SKIP;
  endfunction

  // Over-current only counts when the pulse is on and blanking has run out.
  function automatic logic csk_trip(input logic on, input logic blanking,
                                    input logic ilim);
    return on && !blanking && ilim;
  endfunction

  // Any reason that ends the pulse for the rest of the period.
  function automatic logic csk_must_end(input logic dmax, input logic prot,
                                        input logic trip);
    return !dmax || !prot || trip;
  endfunction

endpackage

// File: rtl/csk_start_edge.sv
module csk_start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i && !strobe_q;
endmodule

// File: rtl/csk_leb_timer.sv
module csk_leb_timer #(
  parameter int BLANK_CYC = 55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic blanking_o
);
  localparam int BW = $clog2(BLANK_CYC + 2);
  localparam logic [BW-1:0] LOAD_VAL = BW'(BLANK_CYC);

  logic [BW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain_q <= '0;
    else if (load_i)         remain_q <= LOAD_VAL;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign blanking_o = (remain_q != '0);
endmodule

// File: rtl/csk_gate_latch.sv
module csk_gate_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic on_o
);
  // A new period start wins over a clear left over from the previous one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_o <= 1'b0;
    else if (set_i) on_o <= 1'b1;
    else if (clr_i) on_o <= 1'b0;
  end
endmodule

// File: rtl/csk_cycle_tally.sv
module csk_cycle_tally
  import csk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  csk_dec_e         dec_i,
  output logic [CNT_W-1:0] on_cnt_o,
  output logic [CNT_W-1:0] skip_cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt_o   <= '0;
      skip_cnt_o <= '0;
    end else begin
      case (dec_i)
        DEC_TAKE: on_cnt_o   <= on_cnt_o + 1'b1;
        DEC_SKIP: skip_cnt_o <= skip_cnt_o + 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/csk_switch_ctrl.sv
module csk_switch_ctrl
  import csk_pkg::*;
#(
  parameter int BLANK_CYC = 55,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start_i,
  input  logic             dmax_win_i,
  input  logic             fb_en_i,
  input  logic             ilim_i,
  input  logic             prot_en_i,
  output logic             gate_req_o,
  output logic [CNT_W-1:0] cyc_on_cnt_o,
  output logic [CNT_W-1:0] cyc_skip_cnt_o
);
  // Named internal events, visible to the bound checker.
  logic     start_pulse;
  logic     blank_active;
  logic     gate_q;
  logic     ilim_trip;
  logic     gate_set;
  logic     gate_clr;
  csk_dec_e decision;

  csk_start_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (cyc_start_i),
    .rise_o   (start_pulse)
  );

  always_comb begin
    decision  = csk_decide(start_pulse, fb_en_i, dmax_win_i, prot_en_i);
    gate_set  = (decision == DEC_TAKE);
    ilim_trip = csk_trip(gate_q, blank_active, ilim_i);
    gate_clr  = csk_must_end(dmax_win_i, prot_en_i, ilim_trip);
  end

  csk_leb_timer #(.BLANK_CYC(BLANK_CYC)) u_leb (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (gate_set),
    .blanking_o (blank_active)
  );

  csk_gate_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (gate_set),
    .clr_i (gate_clr),
    .on_o  (gate_q)
  );

  csk_cycle_tally #(.CNT_W(CNT_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_i      (decision),
    .on_cnt_o   (cyc_on_cnt_o),
    .skip_cnt_o (cyc_skip_cnt_o)
  );

  // The protection enable gates the output directly, with no register delay.
  assign gate_req_o = gate_q && prot_en_i;
endmodule

// File: rtl/csk_switch_ctrl_chk.sv
module csk_switch_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dmax_win_i,
  input logic             fb_en_i,
  input logic             ilim_i,
  input logic             prot_en_i,
  input logic             start_pulse,
  input logic             blank_active,
  input logic             gate_q,
  input logic [CNT_W-1:0] cyc_on_cnt_o,
  input logic [CNT_W-1:0] cyc_skip_cnt_o
);
  p_on_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(start_pulse && fb_en_i && dmax_win_i && prot_en_i));

  p_skip_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !fb_en_i) |=> !gate_q);

  p_fb_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && dmax_win_i && prot_en_i && !(ilim_i && !blank_active)) |=> gate_q);

  p_trip_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !blank_active && ilim_i && !start_pulse) |=> !gate_q);

  p_blank_at_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> blank_active);

  p_dmax_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dmax_win_i |=> !gate_q);

  p_prot_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en_i |=> !gate_q);

  p_tally_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (CNT_W'(cyc_on_cnt_o + cyc_skip_cnt_o) ==
                     CNT_W'($past(cyc_on_cnt_o) + $past(cyc_skip_cnt_o) + 1'b1)));

  p_tally_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_pulse |=> ($stable(cyc_on_cnt_o) && $stable(cyc_skip_cnt_o)));

  p_single_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

bind csk_switch_ctrl csk_switch_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dmax_win_i     (dmax_win_i),
  .fb_en_i        (fb_en_i),
  .ilim_i         (ilim_i),
  .prot_en_i      (prot_en_i),
  .start_pulse    (start_pulse),
  .blank_active   (blank_active),
  .gate_q         (gate_q),
  .cyc_on_cnt_o   (cyc_on_cnt_o),
  .cyc_skip_cnt_o (cyc_skip_cnt_o)
);

// File: tb/csk_switch_ctrl_test.sv
`timescale 1ns/1ps
module csk_switch_ctrl_test;
  localparam int BLANK = 55;
  localparam int CW    = 16;
  localparam int PER   = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_start = 1'b0, dmax_win = 1'b0, fb_en = 1'b0;
  logic          ilim = 1'b0, prot_en = 1'b1;
  logic          gate_req;
  logic [CW-1:0] on_cnt, skip_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_on   = 0;
  int exp_skip = 0;
  int width_acc = 0;
  bit finished = 1'b0;
  int    exp_w_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  csk_switch_ctrl #(.BLANK_CYC(BLANK), .CNT_W(CW)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cyc_start_i    (cyc_start),
    .dmax_win_i     (dmax_win),
    .fb_en_i        (fb_en),
    .ilim_i         (ilim),
    .prot_en_i      (prot_en),
    .gate_req_o     (gate_req),
    .cyc_on_cnt_o   (on_cnt),
    .cyc_skip_cnt_o (skip_cnt)
  );

  task automatic check_int(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Expected pulse width in clocks, derived from the requirements.
  function automatic int calc_width(input bit fb0, input int i_from, input int i_to,
                                    input int p_at, input int dmax);
    int w;
    int trip;
    if (!fb0 || p_at == 0 || dmax == 0) return 0;
    w = dmax;
    trip = (i_from > BLANK + 1) ? i_from : BLANK + 1;
    if (i_from >= 0 && trip < i_to && trip < w) w = trip;
    if (p_at > 0 && p_at - 1 < w) w = p_at - 1;
    return w;
  endfunction

  // Driver: one oscillator period; the expected width goes to the scoreboard.
  task automatic run_period(input string tag, input bit fb0, input bit fb_rest,
                            input int i_from, input int i_to, input int p_at,
                            input int dmax);
    for (int k = 0; k < PER; k++) begin
      @(posedge clk); #1;
      cyc_start = (k < 4);
      dmax_win  = (k < dmax);
      fb_en     = (k == 0) ? fb0 : fb_rest;
      ilim      = (i_from >= 0) && (k >= i_from) && (k < i_to);
      prot_en   = !((p_at >= 0) && (k >= p_at) && (k < p_at + 3));
    end
    @(negedge clk); #1;
    if (fb0 && p_at != 0 && dmax > 0) exp_on++;
    else exp_skip++;
    exp_w_q.push_back(calc_width(fb0, i_from, i_to, p_at, dmax));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: accumulates the on-time and compares once a period is complete.
  initial begin
    forever begin
      @(negedge clk);
      width_acc += int'(gate_req);
      if (exp_w_q.size() != 0) begin
        check_int(tag_q.pop_front(), width_acc, exp_w_q.pop_front());
        width_acc = 0;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_int("R1 gate after reset", int'(gate_req), 0);
    check_int("R1 on count after reset", int'(on_cnt), 0);
    check_int("R1 skip count after reset", int'(skip_cnt), 0);

    run_period("R2 plain taken period",            1'b1, 1'b1, -1, 0, -1, 80);
    run_period("R3 skipped period",                1'b0, 1'b0, -1, 0, -1, 80);
    run_period("R4 fb drop after sample",          1'b1, 1'b0, -1, 0, -1, 80);
    run_period("R4 R10 fb rise after sample",      1'b0, 1'b1, -1, 0, -1, 80);
    run_period("R5 trip after blanking",           1'b1, 1'b1, 60, PER, -1, 80);
    run_period("R5 trip then ilim released",       1'b1, 1'b1, 60, 66, -1, 80);
    run_period("R6 ilim high from start",          1'b1, 1'b1, 0, PER, -1, 80);
    run_period("R6 ilim inside blanking only",     1'b1, 1'b1, 20, 50, -1, 80);
    run_period("R7 short duty window",             1'b1, 1'b1, -1, 0, -1, 30);
    run_period("R8 protection drop mid pulse",     1'b1, 1'b1, -1, 0, 10, 80);
    run_period("R8 protection low at start",       1'b1, 1'b1, -1, 0, 0, 80);
    run_period("R2 taken again after faults",      1'b1, 1'b1, -1, 0, -1, 80);

    repeat (3) @(negedge clk);
    check_int("R9 enabled tally", int'(on_cnt), exp_on);
    check_int("R9 skipped tally", int'(skip_cnt), exp_skip);
    summary();
  end
endmodule